// File: doc/BRIEF.md
# Bit-Serial Lock-Step Processor Array

This block is a two-dimensional grid of very small processing elements. They all obey one instruction stream from a central sequencer. Every element holds a private one-bit-wide memory, a single-bit ALU with a carry register, and an activity flag. An instruction names a base address for each of two source operands and one destination, together with an operand length. The sequencer then steps through the operands one bit per cycle, lowest bit first. All elements perform the same bit step in the same cycle, each on its own data, and the elements never need to synchronise with each other.

The neighbour links wrap at both edges of the grid, so the grid forms a torus. A shift instruction makes every element take its operand bit from one chosen neighbour. The whole grid therefore permutes a field in one pass. A compare instruction clears the activity flag of elements whose operands differ. Those elements then sit idle through later instructions until a set-all instruction re-enables them. A host loads and reads the element memories while the array is idle, and uses a start/done pair to run each instruction.

Top module: `simd_array`

## Requirements
- R1: Every active element carries out each started instruction in the same cycles as every other element, on the bits of its own memory.
- R2: The instruction word is {op[27:24], dst[23:18], srca[17:12], srcb[11:6], lenm1[5:0]}. The operand length is lenm1+1 (1 to 64). Operand bit i is stored at address (base+i) mod 64, least significant bit first. Opcodes: 0 add, 1 and, 2 or, 3 xor, 4 copy, 5 compare, 6 set-all, 8 north, 9 south, 10 east, 11 west.
- R3: Add writes (srca + srcb) mod 2^len to dst. The carry is zero before bit 0.
- R4: And, or and xor write the bitwise result of srca and srcb to dst. Copy writes srca to dst.
- R5: Compare leaves an active element active only if all len bit pairs of srca and srcb are equal; otherwise the element becomes inactive. An inactive element writes nothing and keeps its flag, including on a later compare.
- R6: Set-all makes every element active again, whatever its previous state.
- R7: After start is accepted, busy stays high for exactly len cycles. done is a one-cycle pulse in the cycle after the last bit, so a 16-bit operation takes twice the cycles of an 8-bit one.
- R8: A start while busy is ignored: it changes neither the memory nor the timing of the running instruction.
- R9: Element index is row*4+col. North takes the srca bit of the element at row-1, south takes it from row+1, east from col+1 and west from col-1, all modulo 4, and writes it to dst. Inactive elements still send.
- R10: A host write to (host_pe, host_addr) takes effect only while idle; while busy it is dropped. host_rdata shows the addressed bit one cycle after the address is presented.
- R11: After reset, busy, done and host_rdata are 0 and every element is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run the instruction on instr (taken only when idle) |
| instr | input | 28 | Broadcast instruction word |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle pulse after the last bit |
| host_we | input | 1 | Host write strobe |
| host_pe | input | 4 | Element selected for host access |
| host_addr | input | 6 | Bit address for host access |
| host_wdata | input | 1 | Host write data |
| host_rdata | output | 1 | Registered read of the selected bit |

## Verification
The assertions assume that the host holds start low until it wants a new instruction and that reset is applied at time zero. They also assume that opcodes outside the listed set are never issued. The stimulus keeps each instruction's destination field apart from its source fields. A bit that is read later in an operation is therefore never one that was written earlier in it. The only starts and host writes issued during a run are the deliberate ones in the busy-overlap case.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD    = 4'd0,
    OP_AND    = 4'd1,
    OP_OR     = 4'd2,
    OP_XOR    = 4'd3,
    OP_COPY   = 4'd4,
    OP_CMP    = 4'd5,
    OP_SETALL = 4'd6,
    OP_SHN    = 4'd8,
    OP_SHS    = 4'd9,
    OP_SHE    = 4'd10,
    OP_SHW    = 4'd11
  } op_e;
endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [OP_W+4*AW-1:0]  instr,
  output logic                  busy,
  output logic                  done,
  output op_e                   op,
  output logic [AW-1:0]         ra,
  output logic [AW-1:0]         rb,
  output logic [AW-1:0]         wa,
  output logic                  first,
  output logic                  last
);
  logic [AW-1:0] dst_q, sa_q, sb_q, lenm1_q, cnt_q;
  op_e           op_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      cnt_q   <= '0;
      dst_q   <= '0;
      sa_q    <= '0;
      sb_q    <= '0;
      lenm1_q <= '0;
      op_q    <= OP_SETALL;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        op_q    <= op_e'(instr[OP_W+4*AW-1 -: OP_W]);
        dst_q   <= instr[4*AW-1 -: AW];
        sa_q    <= instr[3*AW-1 -: AW];
        sb_q    <= instr[2*AW-1 -: AW];
        lenm1_q <= instr[AW-1:0];
        cnt_q   <= '0;
        busy    <= 1'b1;
      end else if (busy) begin
        if (cnt_q == lenm1_q) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign op    = op_q;
  assign ra    = sa_q + cnt_q;
  assign rb    = sb_q + cnt_q;
  assign wa    = dst_q + cnt_q;
  assign first = (cnt_q == '0);
  assign last  = (cnt_q == lenm1_q);
endmodule

// File: rtl/simd_pe.sv
module simd_pe
  import simd_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  op_e           op,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  input  logic [AW-1:0] wa,
  input  logic          first,
  input  logic          last,
  input  logic          nbr_n,
  input  logic          nbr_s,
  input  logic          nbr_e,
  input  logic          nbr_w,
  output logic          bit_a,
  output logic          act,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic          host_wdata,
  output logic          host_bit
);
  logic mem [DEPTH];
  logic bit_b, carry_q, eq_q, act_q;
  logic c_in, eq_in, res, wr;

  assign bit_a    = mem[ra];
  assign bit_b    = mem[rb];
  assign host_bit = mem[host_addr];
  assign act      = act_q;
  assign c_in     = first ? 1'b0 : carry_q;
  assign eq_in    = first ? 1'b1 : eq_q;

  always_comb begin
    wr  = 1'b1;
    res = 1'b0;
    case (op)
      OP_ADD:  res = bit_a ^ bit_b ^ c_in;
      OP_AND:  res = bit_a & bit_b;
      OP_OR:   res = bit_a | bit_b;
      OP_XOR:  res = bit_a ^ bit_b;
      OP_COPY: res = bit_a;
      OP_SHN:  res = nbr_n;
      OP_SHS:  res = nbr_s;
      OP_SHE:  res = nbr_e;
      OP_SHW:  res = nbr_w;
      default: wr  = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (host_we)
      mem[host_addr] <= host_wdata;
    else if (en && act_q && wr)
      mem[wa] <= res;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= 1'b0;
      eq_q    <= 1'b1;
      act_q   <= 1'b1;
    end else if (en) begin
      if (op == OP_SETALL) begin
        act_q <= 1'b1;
      end else if (act_q) begin
        carry_q <= (bit_a & bit_b) | (c_in & (bit_a ^ bit_b));
        eq_q    <= eq_in & (bit_a == bit_b);
        if (op == OP_CMP && last)
          act_q <= eq_in & (bit_a == bit_b);
      end
    end
  end
endmodule

// File: rtl/simd_array.sv
module simd_array
  import simd_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int NPE  = ROWS * COLS,
  localparam int PW   = $clog2(NPE),
  localparam int IW   = OP_W + 4 * AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [IW-1:0] instr,
  output logic          busy,
  output logic          done,
  input  logic          host_we,
  input  logic [PW-1:0] host_pe,
  input  logic [AW-1:0] host_addr,
  input  logic          host_wdata,
  output logic          host_rdata
);
  op_e            ctl_op;
  logic [AW-1:0]  ctl_ra, ctl_rb, ctl_wa;
  logic           ctl_first, ctl_last;
  logic [NPE-1:0] bit_a, act_vec, host_bits;

  simd_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .instr(instr),
    .busy(busy), .done(done), .op(ctl_op),
    .ra(ctl_ra), .rb(ctl_rb), .wa(ctl_wa),
    .first(ctl_first), .last(ctl_last)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int IDX = r * COLS + c;
      localparam int N_I = ((r + ROWS - 1) % ROWS) * COLS + c;
      localparam int S_I = ((r + 1) % ROWS) * COLS + c;
      localparam int E_I = r * COLS + (c + 1) % COLS;
      localparam int W_I = r * COLS + (c + COLS - 1) % COLS;
      logic pe_we;
      assign pe_we = host_we && !busy && (host_pe == PW'(IDX));

      simd_pe #(.DEPTH(DEPTH), .AW(AW)) u_pe (
        .clk(clk), .rst(rst), .en(busy), .op(ctl_op),
        .ra(ctl_ra), .rb(ctl_rb), .wa(ctl_wa),
        .first(ctl_first), .last(ctl_last),
        .nbr_n(bit_a[N_I]), .nbr_s(bit_a[S_I]),
        .nbr_e(bit_a[E_I]), .nbr_w(bit_a[W_I]),
        .bit_a(bit_a[IDX]), .act(act_vec[IDX]),
        .host_we(pe_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_bit(host_bits[IDX])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= 1'b0;
    else     host_rdata <= host_bits[host_pe];
  end
endmodule

// File: rtl/simd_array_chk.sv
module simd_array_chk
  import simd_pkg::*;
#(
  parameter int NPE = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           busy,
  input logic           done,
  input op_e            ctl_op,
  input logic [NPE-1:0] act_vec
);
  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  a_r7_busy_ends_in_done: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));

  a_r8_start_taken_when_idle: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  a_r5_flags_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(act_vec));

  a_r5_flags_rise_only_setall: assert property (@(posedge clk) disable iff (rst)
    (busy && ctl_op != OP_SETALL) |=> ((act_vec & ~$past(act_vec)) == '0));

  a_r6_setall_enables_all: assert property (@(posedge clk) disable iff (rst)
    (busy && ctl_op == OP_SETALL) |=> (&act_vec));
endmodule

bind simd_array simd_array_chk #(.NPE(NPE)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .ctl_op(ctl_op), .act_vec(act_vec)
);

// File: tb/simd_array_tb.sv
`timescale 1ns/1ps
module simd_array_tb;
  logic        clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [27:0] instr = '0;
  logic        busy, done, host_we = 1'b0, host_wdata = 1'b0, host_rdata;
  logic [3:0]  host_pe = '0;
  logic [5:0]  host_addr = '0;

  int n_chk = 0, n_fail = 0;
  bit mdl [16][64];
  bit act [16];

  typedef struct { int pe; int addr; bit exp; string req; } item_t;
  item_t sbq[$];

  always #2.5 clk = ~clk;

  simd_array u_dut (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .busy(busy), .done(done),
    .host_we(host_we), .host_pe(host_pe), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  task automatic check(bit ok, string req, int got, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got %0d exp %0d", req, got, exp);
    end
  endtask

  function automatic int nbr(int pe, int op);
    int r = pe / 4, c = pe % 4;
    case (op)
      8:  return ((r + 3) % 4) * 4 + c;
      9:  return ((r + 1) % 4) * 4 + c;
      10: return r * 4 + (c + 1) % 4;
      default: return r * 4 + (c + 3) % 4;
    endcase
  endfunction

  // driver side: expected bits of a region of every element
  task automatic push_region(int base, int len, string req);
    for (int pe = 0; pe < 16; pe++)
      for (int i = 0; i < len; i++) begin
        item_t it;
        it.pe = pe; it.addr = (base + i) % 64; it.exp = mdl[pe][(base + i) % 64]; it.req = req;
        sbq.push_back(it);
      end
  endtask

  // monitor side: read back through the host port and compare
  task automatic drain();
    while (sbq.size() > 0) begin
      item_t it = sbq.pop_front();
      host_pe = 4'(it.pe); host_addr = 6'(it.addr);
      @(negedge clk);
      check(host_rdata == it.exp, it.req, host_rdata, it.exp);
    end
  endtask

  task automatic hwrite(int pe, int addr, bit v);
    host_we = 1'b1; host_pe = 4'(pe); host_addr = 6'(addr); host_wdata = v;
    mdl[pe][addr] = v;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  function automatic longint field(int pe, int base, int len);
    longint v = 0;
    for (int i = 0; i < len; i++) if (mdl[pe][(base + i) % 64]) v |= (64'd1 << i);
    return v;
  endfunction

  task automatic model(int op, int dst, int sa, int sb, int len);
    bit src [16][64] = mdl;
    if (op == 6) begin
      for (int pe = 0; pe < 16; pe++) act[pe] = 1'b1;
      return;
    end
    for (int pe = 0; pe < 16; pe++) begin
      longint a, b, r;
      if (!act[pe]) continue;
      a = 0; b = 0;
      for (int i = 0; i < len; i++) begin
        if (src[pe][(sa + i) % 64]) a |= (64'd1 << i);
        if (src[pe][(sb + i) % 64]) b |= (64'd1 << i);
      end
      if (op >= 8) begin
        a = 0;
        for (int i = 0; i < len; i++) if (src[nbr(pe, op)][(sa + i) % 64]) a |= (64'd1 << i);
      end
      case (op)
        0: r = a + b;
        1: r = a & b;
        2: r = a | b;
        3: r = a ^ b;
        5: begin act[pe] = (a == b); continue; end
        default: r = a;
      endcase
      for (int i = 0; i < len; i++) mdl[pe][(dst + i) % 64] = r[i];
    end
  endtask

  task automatic run(int op, int dst, int sa, int sb, int len, string req);
    int n = 0;
    start = 1'b1;
    instr = {4'(op), 6'(dst), 6'(sa), 6'(sb), 6'(len - 1)};
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R7 busy after start", busy, 1);
    while (!done && n < 200) begin @(negedge clk); n++; end
    check(n == len, {"R7 cycles ", req}, n, len);
    check(busy == 1'b0, "R7 idle at done", busy, 0);
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", done, 0);
    model(op, dst, sa, sb, len);
    if (op != 5 && op != 6) push_region(dst, len, req);
    drain();
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired got 0 exp 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int seed = 17;
    for (int pe = 0; pe < 16; pe++) act[pe] = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(busy == 1'b0, "R11 busy", busy, 0);
    check(done == 1'b0, "R11 done", done, 0);
    check(host_rdata == 1'b0, "R11 rdata", host_rdata, 0);

    // R10: load and read back every bit
    for (int pe = 0; pe < 16; pe++)
      for (int a = 0; a < 64; a++) begin
        seed = seed * 1103515245 + 12345;
        hwrite(pe, a, seed[16]);
      end
    push_region(0, 64, "R10 load");
    drain();

    // R11/R1 all active after reset; R3 add; R7 length timing
    run(0, 32, 0, 16, 8, "R3 add8");
    run(0, 32, 0, 16, 16, "R3 add16");
    run(0, 48, 62, 14, 4, "R2 add wrap");
    run(0, 52, 5, 21, 1, "R2 add len1");
    run(1, 32, 0, 16, 8, "R4 and");
    run(2, 32, 3, 19, 8, "R4 or");
    run(3, 32, 6, 22, 8, "R4 xor");
    run(4, 40, 9, 0, 8, "R4 copy");

    // R5: even elements match, odd elements differ
    for (int pe = 0; pe < 16; pe++)
      for (int i = 0; i < 4; i++) begin
        hwrite(pe, 56 + i, pe[i]);
        hwrite(pe, 52 + i, (pe % 2 == 0) ? pe[i] : ~pe[i]);
      end
    run(5, 0, 52, 56, 4, "R5 cmp");
    run(4, 32, 0, 0, 8, "R5 masked copy");
    for (int i = 0; i < 4; i++) hwrite(4, 52 + i, ~mdl[4][52 + i]);
    run(5, 0, 52, 56, 4, "R5 cmp nested");
    run(0, 40, 8, 24, 8, "R5 masked add");
    run(10, 32, 16, 0, 8, "R9 east under mask");
    run(6, 0, 0, 0, 1, "R6 setall");
    run(4, 32, 24, 0, 8, "R6 copy after setall");

    // R9 torus shifts
    run(8, 32, 0, 0, 8, "R9 north");
    run(9, 32, 8, 0, 8, "R9 south");
    run(10, 40, 16, 0, 8, "R9 east");
    run(11, 40, 24, 0, 8, "R9 west");

    // R8 / R10: start and host write while busy
    begin
      int n = 0;
      bit keep = mdl[0][60];
      start = 1'b1;
      instr = {4'd0, 6'd32, 6'd0, 6'd16, 6'd15};
      @(negedge clk);
      start = 1'b0;
      while (!done && n < 200) begin
        if (n == 3) begin
          start = 1'b1; instr = {4'd4, 6'd48, 6'd0, 6'd0, 6'd3};
          host_we = 1'b1; host_pe = 4'd0; host_addr = 6'd60; host_wdata = ~keep;
        end else begin
          start = 1'b0; host_we = 1'b0;
        end
        @(negedge clk); n++;
      end
      start = 1'b0; host_we = 1'b0;
      check(n == 16, "R8 timing unchanged", n, 16);
      repeat (3) begin
        @(negedge clk);
        check(busy == 1'b0, "R8 no second run", busy, 0);
      end
      model(0, 32, 0, 16, 16);
      push_region(32, 16, "R8 add result");
      push_region(48, 4, "R8 copy ignored");
      drain();
      host_pe = 4'd0; host_addr = 6'd60;
      @(negedge clk);
      check(host_rdata == keep, "R10 busy write dropped", host_rdata, keep);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule